// File: doc/BRIEF.md
# Faulting Instruction Capture Registers

This block holds two read-only 32-bit capture registers that sit in the system-control coprocessor's register space at register number 8. On the cycle a synchronous exception commits, the first register records the instruction word that faulted. The second register records the branch that came before it, but only when the faulting instruction was in a branch delay slot. A fetch-side fault that has no valid instruction word, such as a misaligned program counter or a translation miss on fetch, leaves the faulting-word register unchanged.

Software reads the registers through a register/select access port. Writes to them are accepted and dropped. Each register has its own configuration presence input. When a register is absent it reads as zero, the value used for an unimplemented register. A wide read returns the 32-bit value sign-extended to 64 bits. Select 0 at register 8 holds the bad virtual address, which lives in a neighbouring block, so this block answers that select with zero and no error. Any select above 2 at register 8 is flagged as illegal.

Top module: `fault_instr_capture`

## Requirements
- R1: After synchronous active-low reset, both capture registers hold zero, and a read of register 8 select 1 or select 2 returns zero.
- R2: On a clock edge where `exc_commit` is 1 and `exc_word_unavail` is 0, the faulting-word register (register 8, select 1) loads `exc_instr`.
- R3: On a clock edge where `exc_commit` is 1 and `exc_word_unavail` is 1, the faulting-word register keeps its previous value.
- R4: On a clock edge where `exc_commit` is 1 and `exc_in_delay_slot` is 1, the prior-branch register (register 8, select 2) loads `exc_prev_instr`, whatever the value of `exc_word_unavail`.
- R5: On a commit with `exc_in_delay_slot` at 0, the prior-branch register keeps its previous value.
- R6: On clock edges where `exc_commit` is 0, both registers hold their values.
- R7: A write (`acc_valid`=1, `acc_write`=1) to register 8 at select 0, 1 or 2 changes neither register and does not raise `acc_illegal`.
- R8: A read of select 1 while `cfg_fault_present` is 0, or of select 2 while `cfg_branch_present` is 0, returns all zeros.
- R9: A read with `acc_wide`=1 returns bit 31 of the value copied into bits 63:32. A read with `acc_wide`=0 returns zero in bits 63:32.
- R10: Any access to register 8 at a select of 3 to 7 drives `acc_illegal` to 1 and `rd_data` to zero, and changes neither register.
- R11: Reads are combinational from the stored state. A read in the same cycle as a commit returns the value from before that commit, and the new value appears from the next cycle.
- R12: `rd_data` is zero and `acc_illegal` is 0 in these cases: `acc_valid` is 0, the access is a write, the register number is not 8, or the access is to register 8 select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_commit | input | 1 | High for the single cycle an exception is taken |
| exc_instr | input | 32 | Instruction word that caused the exception |
| exc_prev_instr | input | 32 | Instruction word before the faulting one (the branch) |
| exc_in_delay_slot | input | 1 | Faulting instruction lies in a branch delay slot |
| exc_word_unavail | input | 1 | Fault came from fetch, so no valid instruction word exists |
| cfg_fault_present | input | 1 | Faulting-word register is implemented |
| cfg_branch_present | input | 1 | Prior-branch register is implemented |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 for a move-to (write), 0 for a move-from (read) |
| acc_reg | input | 5 | Coprocessor register number |
| acc_sel | input | 3 | Register select |
| acc_wdata | input | 32 | Write data (discarded) |
| acc_wide | input | 1 | 64-bit read path: sign-extend the result |
| rd_data | output | 64 | Read data |
| acc_illegal | output | 1 | Access to register 8 at an undefined select |

## Verification
Assertions check the following on every cycle:
- Each capture register loads on its own commit condition and otherwise holds (R2 to R6).
- An illegal access reads as zero (R10).
- An absent register reads as zero (R8).
- The upper half of a wide read copies bit 31 (R9).

Some behaviour only the bench scenarios can show:
- The value read in the same cycle as a commit, compared with the value read in the cycle after it.
- Discarded writes, shown by reading the registers back through the port.
- Reset contents.
- Zero returned for foreign registers and for select 0.

These are checked both by directed cases and by a seeded random mix of commits, flag combinations and accesses, all compared against a bench reference model.

// File: rtl/fwc_pkg.sv
// Package: shared select codes and the decoded access kind for the
// faulting-instruction capture block. Assumes register 8 selects 1 and 2
// belong to this block and select 0 belongs to a neighbour.
package fwc_pkg;
    localparam int SEL_VADDR  = 0;
    localparam int SEL_FAULT  = 1;
    localparam int SEL_BRANCH = 2;
    localparam int NUM_SLOTS  = 2;

    // Decoded meaning of the current access.
    typedef enum logic [1:0] {
        SLOT_NONE   = 2'd0,
        SLOT_FAULT  = 2'd1,
        SLOT_BRANCH = 2'd2,
        SLOT_BAD    = 2'd3
    } slot_e;
endpackage

// File: rtl/fwc_capture_reg.sv
// Module: one capture register with load enable and synchronous
// active-low reset to zero. Assumes load is already qualified by commit.
module fwc_capture_reg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] q
);
    // Purpose: clear on reset, take din on load, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= din;
    end

    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> q == $past(q)); // R6
endmodule

// File: rtl/fwc_decode.sv
// Module: decodes a register/select access into the slot it targets.
// Reads of selects 1 and 2 map to the two capture registers. Writes and
// select 0 map to nothing. Selects above 2 at the home register are bad.
module fwc_decode
    import fwc_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int SEL_W    = 3,
    parameter int HOME_REG = 8
) (
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [REG_W-1:0] acc_reg,
    input  logic [SEL_W-1:0] acc_sel,
    output slot_e            slot
);
    localparam logic [REG_W-1:0] HOME = REG_W'(HOME_REG);

    // Purpose: classify the access by register number, select and direction.
    always_comb begin
        slot = SLOT_NONE;
        if (acc_valid && acc_reg == HOME) begin
            if (acc_sel > SEL_W'(SEL_BRANCH))
                slot = SLOT_BAD;
            else if (!acc_write && acc_sel == SEL_W'(SEL_FAULT))
                slot = SLOT_FAULT;
            else if (!acc_write && acc_sel == SEL_W'(SEL_BRANCH))
                slot = SLOT_BRANCH;
        end
    end
endmodule

// File: rtl/fwc_read_path.sv
// Module: read multiplexer with per-register presence gating and optional
// sign extension to the wide read path. Assumes OUT_W is twice WORD_W.
module fwc_read_path
    import fwc_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  slot_e               slot,
    input  logic                fault_present,
    input  logic                branch_present,
    input  logic                wide,
    input  logic [WORD_W-1:0]   fault_word,
    input  logic [WORD_W-1:0]   branch_word,
    output logic [2*WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] word;

    // Purpose: pick the addressed register, zero when absent or unmapped.
    always_comb begin
        word = '0;
        unique case (slot)
            SLOT_FAULT:  if (fault_present)  word = fault_word;
            SLOT_BRANCH: if (branch_present) word = branch_word;
            default:     word = '0;
        endcase
    end

    // Purpose: widen the selected word, sign-extending on wide reads.
    always_comb begin
        rd_data = {{WORD_W{wide & word[WORD_W-1]}}, word};
    end
endmodule

// File: rtl/fault_instr_capture.sv
// Module: top of the faulting-instruction capture pair. Captures the
// faulting word unless the fault had no valid word, and captures the prior
// branch only for delay-slot faults. Reads are combinational, writes are
// dropped. Assumes exc_commit is high for exactly one cycle per exception.
module fault_instr_capture
    import fwc_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int REG_W    = 5,
    parameter int SEL_W    = 3,
    parameter int HOME_REG = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                exc_commit,
    input  logic [WORD_W-1:0]   exc_instr,
    input  logic [WORD_W-1:0]   exc_prev_instr,
    input  logic                exc_in_delay_slot,
    input  logic                exc_word_unavail,
    input  logic                cfg_fault_present,
    input  logic                cfg_branch_present,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [REG_W-1:0]    acc_reg,
    input  logic [SEL_W-1:0]    acc_sel,
    input  logic [WORD_W-1:0]   acc_wdata,
    input  logic                acc_wide,
    output logic [2*WORD_W-1:0] rd_data,
    output logic                acc_illegal
);
    localparam int OUT_W = 2 * WORD_W;

    slot_e             slot;
    logic [NUM_SLOTS-1:0] load;
    logic [WORD_W-1:0] din [NUM_SLOTS];
    logic [WORD_W-1:0] q   [NUM_SLOTS];
    logic              unused_wdata;

    // Purpose: write data is discarded by design; fold it away.
    assign unused_wdata = ^acc_wdata;

    // Purpose: form per-register load enables and data sources.
    always_comb begin
        load[0] = exc_commit && !exc_word_unavail;
        load[1] = exc_commit && exc_in_delay_slot;
        din[0]  = exc_instr;
        din[1]  = exc_prev_instr;
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cap
        fwc_capture_reg #(.WORD_W(WORD_W)) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .load (load[i]),
            .din  (din[i]),
            .q    (q[i])
        );
    end

    fwc_decode #(.REG_W(REG_W), .SEL_W(SEL_W), .HOME_REG(HOME_REG)) u_dec (
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .acc_reg  (acc_reg),
        .acc_sel  (acc_sel),
        .slot     (slot)
    );

    fwc_read_path #(.WORD_W(WORD_W)) u_rd (
        .slot          (slot),
        .fault_present (cfg_fault_present),
        .branch_present(cfg_branch_present),
        .wide          (acc_wide),
        .fault_word    (q[0]),
        .branch_word   (q[1]),
        .rd_data       (rd_data)
    );

    // Purpose: flag undefined selects at the home register.
    assign acc_illegal = (slot == SLOT_BAD);

    AST_FAULT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_commit && !exc_word_unavail |=> q[0] == $past(exc_instr)); // R2
    AST_FAULT_KEPT_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        exc_commit && exc_word_unavail |=> $stable(q[0])); // R3
    AST_BRANCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_commit && exc_in_delay_slot |=> q[1] == $past(exc_prev_instr)); // R4
    AST_BRANCH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        exc_commit && !exc_in_delay_slot |=> $stable(q[1])); // R5
    AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        acc_illegal |-> rd_data == '0); // R10
    AST_ABSENT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_FAULT && !cfg_fault_present) ||
        (slot == SLOT_BRANCH && !cfg_branch_present) |-> rd_data == '0); // R8
    AST_WIDE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wide |-> rd_data[OUT_W-1:WORD_W] == {WORD_W{rd_data[WORD_W-1]}}); // R9
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wide |-> rd_data[OUT_W-1:WORD_W] == '0); // R9
endmodule

// File: tb/fault_instr_capture_test.sv
module fault_instr_capture_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_commit, exc_in_delay_slot, exc_word_unavail;
    logic [31:0] exc_instr, exc_prev_instr;
    logic        cfg_fault_present, cfg_branch_present;
    logic        acc_valid, acc_write, acc_wide;
    logic [4:0]  acc_reg;
    logic [2:0]  acc_sel;
    logic [31:0] acc_wdata;
    logic [63:0] rd_data;
    logic        acc_illegal;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_fault, m_branch;

    always #10 clk = ~clk;

    fault_instr_capture uut (
        .clk(clk), .rst_n(rst_n), .exc_commit(exc_commit), .exc_instr(exc_instr),
        .exc_prev_instr(exc_prev_instr), .exc_in_delay_slot(exc_in_delay_slot),
        .exc_word_unavail(exc_word_unavail), .cfg_fault_present(cfg_fault_present),
        .cfg_branch_present(cfg_branch_present), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_reg(acc_reg), .acc_sel(acc_sel),
        .acc_wdata(acc_wdata), .acc_wide(acc_wide), .rd_data(rd_data),
        .acc_illegal(acc_illegal)
    );

    function automatic logic exp_ill(logic v, logic [4:0] r, logic [2:0] s);
        return v && r == 5'd8 && s > 3'd2;
    endfunction

    function automatic logic [63:0] exp_rd(logic v, logic w, logic [4:0] r, logic [2:0] s,
                                           logic wide, logic cf, logic cb,
                                           logic [31:0] f, logic [31:0] b);
        logic [31:0] word = 32'h0;
        if (v && !w && r == 5'd8) begin
            if (s == 3'd1 && cf) word = f;
            if (s == 3'd2 && cb) word = b;
        end
        return {{32{wide & word[31]}}, word};
    endfunction

    task automatic chk(string tag);
        logic [63:0] e;
        logic        ei;
        #1;
        e  = exp_rd(acc_valid, acc_write, acc_reg, acc_sel, acc_wide,
                    cfg_fault_present, cfg_branch_present, m_fault, m_branch);
        ei = exp_ill(acc_valid, acc_reg, acc_sel);
        n_chk++;
        if (rd_data !== e || acc_illegal !== ei) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h illegal=%b expected rd_data=%h illegal=%b",
                     tag, rd_data, acc_illegal, e, ei);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_fault = 32'h0; m_branch = 32'h0;
        end else if (exc_commit) begin
            if (!exc_word_unavail) m_fault = exc_instr;
            if (exc_in_delay_slot) m_branch = exc_prev_instr;
        end
        @(negedge clk);
    endtask

    task automatic set_exc(logic c, logic [31:0] i, logic [31:0] p, logic ds, logic un);
        exc_commit = c; exc_instr = i; exc_prev_instr = p;
        exc_in_delay_slot = ds; exc_word_unavail = un;
    endtask

    task automatic set_acc(logic v, logic w, logic [4:0] r, logic [2:0] s, logic wide);
        acc_valid = v; acc_write = w; acc_reg = r; acc_sel = s; acc_wide = wide;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        m_fault = '0; m_branch = '0;
        rst_n = 1'b0;
        set_exc(0, 32'h0, 32'h0, 0, 0);
        set_acc(0, 0, 5'd0, 3'd0, 0);
        acc_wdata = 32'h0;
        cfg_fault_present = 1; cfg_branch_present = 1;
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        // Set the registers non-zero, then reset again to check the reset value.
        set_exc(1, 32'hDEAD_0001, 32'hBEEF_0002, 1, 0);
        tick();
        rst_n = 1'b0; set_exc(0, 0, 0, 0, 0);
        tick();
        rst_n = 1'b1;
        set_acc(1, 0, 5'd8, 3'd1, 0); chk("R1 fault reset");
        set_acc(1, 0, 5'd8, 3'd2, 0); chk("R1 branch reset");

        // R2 and R5: commit outside a delay slot.
        set_exc(1, 32'h1234_5678, 32'hAAAA_0000, 0, 0);
        tick(); set_exc(0, 0, 0, 0, 0);
        set_acc(1, 0, 5'd8, 3'd1, 0); chk("R2 fault captured");
        set_acc(1, 0, 5'd8, 3'd2, 0); chk("R5 branch kept");

        // R3 and R4: delay-slot fault with no valid word.
        set_exc(1, 32'h0BAD_0BAD, 32'h1000_FFFF, 1, 1);
        tick(); set_exc(0, 0, 0, 0, 0);
        set_acc(1, 0, 5'd8, 3'd1, 0); chk("R3 fault kept on fetch fault");
        set_acc(1, 0, 5'd8, 3'd2, 0); chk("R4 branch captured");

        // R11: a read in the commit cycle shows the old value, then the new one.
        set_exc(1, 32'hCAFE_F00D, 32'h8765_4321, 1, 0);
        set_acc(1, 0, 5'd8, 3'd1, 0); chk("R11 old value in commit cycle");
        tick(); set_exc(0, 0, 0, 0, 0);
        chk("R11 new value after commit");

        // R9: wide read with bit 31 set, then a narrow read.
        set_acc(1, 0, 5'd8, 3'd1, 1); chk("R9 wide sign extend");
        set_acc(1, 0, 5'd8, 3'd2, 1); chk("R9 wide sign extend branch");
        set_acc(1, 0, 5'd8, 3'd1, 0); chk("R9 narrow upper zero");

        // R7: writes to selects 0..2 are dropped.
        for (int s = 0; s < 3; s++) begin
            acc_wdata = 32'hFFFF_FFFF;
            set_acc(1, 1, 5'd8, 3'(s), 0); chk("R7 write no illegal");
            tick();
        end
        set_acc(1, 0, 5'd8, 3'd1, 0); chk("R7 fault unchanged after write");
        set_acc(1, 0, 5'd8, 3'd2, 0); chk("R7 branch unchanged after write");

        // R10: undefined selects flag illegal and change nothing.
        for (int s = 3; s < 8; s++) begin
            set_acc(1, s[0], 5'd8, 3'(s), 1); chk("R10 illegal select");
            tick();
        end
        set_acc(1, 0, 5'd8, 3'd1, 0); chk("R10 fault unchanged");
        set_acc(1, 0, 5'd8, 3'd2, 0); chk("R10 branch unchanged");

        // R8: absent registers read zero.
        cfg_fault_present = 0;
        set_acc(1, 0, 5'd8, 3'd1, 1); chk("R8 absent fault");
        cfg_fault_present = 1; cfg_branch_present = 0;
        set_acc(1, 0, 5'd8, 3'd2, 1); chk("R8 absent branch");
        cfg_branch_present = 1;

        // R12: foreign register, select 0, no access.
        set_acc(1, 0, 5'd9, 3'd1, 1); chk("R12 other register");
        set_acc(1, 0, 5'd8, 3'd0, 1); chk("R12 select 0");
        set_acc(0, 0, 5'd8, 3'd1, 1); chk("R12 no access");

        // R6: idle cycles hold.
        tick(); tick();
        set_acc(1, 0, 5'd8, 3'd2, 0); chk("R6 hold while idle");

        // Random mix.
        for (int n = 0; n < 400; n++) begin
            string tag;
            set_exc(($urandom % 3) == 0, $urandom, $urandom,
                    $urandom % 2, ($urandom % 4) == 0);
            cfg_fault_present  = ($urandom % 6) != 0;
            cfg_branch_present = ($urandom % 6) != 0;
            acc_wdata = $urandom;
            set_acc(($urandom % 8) != 0, ($urandom % 5) == 0,
                    (($urandom % 4) != 0) ? 5'd8 : 5'($urandom),
                    3'($urandom), $urandom % 2);
            if (exp_ill(acc_valid, acc_reg, acc_sel)) tag = "R10 random";
            else if (!acc_valid || acc_write || acc_reg != 5'd8 || acc_sel == 3'd0) tag = "R12 random";
            else if (!(acc_sel == 3'd1 ? cfg_fault_present : cfg_branch_present)) tag = "R8 random";
            else tag = "R2 R4 R6 random";
            chk(tag);
            tick();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule